// File: doc/BRIEF.md
# Complementary PWM Generator with Per-Event Actions

This block produces a complementary pair of pulse-width-modulated outputs from a 16-bit time-base counter. The counter counts up, counts down, or counts up and then down, between zero and a programmable period. It can be preset to a programmable phase value. Starting and stopping come from software strobes or from external strobes.

Four events can occur on each count: the counter at zero, the counter at the period, a match with compare A, and a match with compare B. A 2-bit action code sets what the primary output does on each event. The secondary output is the complement of the primary, and a dead-band stage delays the rising edge of each output by its own programmable count. A fault input overrides both outputs with a per-output state of low, high or released (output enable deasserted).

Typical use: set the period, the compares and the action codes, choose a count mode, then pulse a start strobe. The raw waveform, the dead-band pair and the fault override all follow from those settings with no further intervention.

Top module: `epwm_pair`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter is cleared, counting stops and the primary waveform is low. On the cycle after reset `pwm_p` is 0, and both output enables are 1 when no fault is present.
- R2: Mode 00 (up): each running cycle the counter steps +1. From a value at or above `period` it goes to 0, so one waveform period is `period`+1 clocks.
- R3: Mode 01 (down): each running cycle the counter steps −1. From 0 it goes to `period`.
- R4: Mode 10 (up-down): the counter rises 0..`period` and then falls back to 0. It reverses at `period` and at 0 with no repeated value, so one waveform period is 2×`period` clocks. Mode 11 behaves as mode 00.
- R5: Action codes are 00 no change, 01 drive low, 10 drive high, 11 toggle. In `act_cfg`, bits [1:0] are zero, [3:2] period, [5:4] A while rising, [7:6] B while rising, [9:8] A while falling and [11:10] B while falling. Rising applies in modes 00/11 and falling in mode 01. In mode 10 the count direction decides, and that direction is the one in which the current value was reached. The action takes effect on the clock after the event count is present.
- R6: When events coincide, only the highest-priority event present decides the action, even if its code is 00. The order is zero, then period, then B, then A.
- R7: A `phase_ld` pulse loads `phase` into the counter on the next edge and sets the direction to rising. This takes priority over counting.
- R8: A start pulse (`sw_start` or `ext_start`) starts counting from the next cycle. A stop pulse (`sw_stop` or `ext_stop`) halts it, and stop wins when both arrive together. While stopped, the counter and the primary waveform hold.
- R9: `pwm_p` rises `db_rise`+1 clocks after the raw waveform rises and falls one clock after it falls. A high pulse of `db_rise` clocks or less never appears.
- R10: `pwm_n` is the complement of the raw waveform with its rising edge delayed by `db_fall`+1 clocks. `pwm_p` and `pwm_n` are never high together without a fault.
- R11: While `trip` is high, each output takes its state code at once (same cycle): 00 drives low, 01 drives high, and 1x releases it (`oe` = 0, level 0). Dropping `trip` returns the dead-band outputs.
- R12: Equal compares A and B are legal; with A = B the B action applies on the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Count mode: 00 up, 01 down, 10 up-down, 11 up |
| period | input | 16 | Counter period, must be > 0 |
| phase | input | 16 | Value preset by `phase_ld` |
| phase_ld | input | 1 | Load pulse for the phase value |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software stop strobe |
| ext_start | input | 1 | External start strobe |
| ext_stop | input | 1 | External stop strobe |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| act_cfg | input | 12 | Six 2-bit action codes (layout in R5) |
| db_rise | input | 16 | Rising-edge delay of `pwm_p` in clocks |
| db_fall | input | 16 | Rising-edge delay of `pwm_n` in clocks |
| trip | input | 1 | Fault input, active high |
| trip_p_cfg | input | 2 | Fault state of the P output |
| trip_n_cfg | input | 2 | Fault state of the N output |
| ctr | output | 16 | Current counter value |
| pwm_p | output | 1 | Primary output level |
| pwm_n | output | 1 | Complementary output level |
| oe_p | output | 1 | Output enable for P |
| oe_n | output | 1 | Output enable for N |

## Verification
The assertions watch, on every cycle, the local invariants. These are the single-step count in up mode, the up-down count staying inside the period, counter and waveform holding while stopped, dead-band outputs rising only after a high input and clearing on a low one, and the pair never being high together. What the assertions cannot show is which event wins a collision, which direction picks a compare code, the exact delay in clocks, the phase preset and the fault states. The bench's behavioural model exposes those by tracking every output on every clock through scenarios built around them.

// File: rtl/epwm_pkg.sv
// Shared types for the complementary PWM generator.
// Assumes 2-bit action and mode encodings as listed in the brief.
package epwm_pkg;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_ALT  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef struct packed {
        logic at_zero;
        logic at_prd;
        logic at_cmpb;
        logic at_cmpa;
        logic rising;
    } tb_evt_t;

    localparam int ACT_W = 12;

    // Next waveform level for a given action code.
    function automatic logic apply_act(input logic cur, input logic [1:0] code);
        case (code)
            ACT_CLR: return 1'b0;
            ACT_SET: return 1'b1;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

    // Fault override: returns {enable, level}.
    function automatic logic [1:0] trip_drive(input logic [1:0] st);
        if (st[1])          return 2'b00;
        else if (st[0])     return 2'b11;
        else                return 2'b10;
    endfunction

endpackage

// File: rtl/epwm_timebase.sv
// Time-base counter with up, down and up-down modes plus phase preset.
// Decodes zero, period and compare events from the current count.
// Assumes period > 0; direction flag only moves in up-down mode.
module epwm_timebase
    import epwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] phase,
    input  logic          phase_ld,
    input  logic [CW-1:0] cmp_a,
    input  logic [CW-1:0] cmp_b,
    output logic [CW-1:0] cnt,
    output tb_evt_t       evt
);

    logic up_q;

    // Advance or preset the counter and its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (phase_ld) begin
            cnt  <= phase;
            up_q <= 1'b1;
        end else if (run) begin
            case (mode)
                MODE_DOWN: cnt <= (cnt == '0) ? period : cnt - 1'b1;
                MODE_UPDN: begin
                    if (up_q) begin
                        if (cnt >= period) begin
                            cnt  <= cnt - 1'b1;
                            up_q <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else if (cnt == '0) begin
                        cnt  <= {{(CW-1){1'b0}}, 1'b1};
                        up_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default:   cnt <= (cnt >= period) ? '0 : cnt + 1'b1;
            endcase
        end
    end

    // Event decode from the present count.
    always_comb begin
        evt.at_zero = (cnt == '0);
        evt.at_prd  = (cnt == period);
        evt.at_cmpa = (cnt == cmp_a);
        evt.at_cmpb = (cnt == cmp_b);
        case (mode)
            MODE_DOWN: evt.rising = 1'b0;
            MODE_UPDN: evt.rising = up_q;
            default:   evt.rising = 1'b1;
        endcase
    end

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_UP && cnt < period && !phase_ld)
        |=> cnt == CW'($past(cnt) + 1'b1));

    // R4
    updn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_UPDN && !phase_ld && cnt <= period)
        |=> cnt <= $past(period));

    // R8
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !phase_ld) |=> $stable(cnt));

endmodule

// File: rtl/epwm_action.sv
// Action qualifier: picks one action code per clock from the event set
// by fixed priority (zero, period, B, A) and updates the raw waveform.
// Assumes act_cfg layout as in the brief; acts only while running.
module epwm_action
    import epwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  tb_evt_t          evt,
    input  logic [ACT_W-1:0] act_cfg,
    output logic             raw
);

    logic [1:0] code;

    // Priority select of the winning event's code.
    always_comb begin
        if (evt.at_zero)      code = act_cfg[1:0];
        else if (evt.at_prd)  code = act_cfg[3:2];
        else if (evt.at_cmpb) code = evt.rising ? act_cfg[7:6] : act_cfg[11:10];
        else if (evt.at_cmpa) code = evt.rising ? act_cfg[5:4] : act_cfg[9:8];
        else                  code = ACT_NONE;
    end

    // Raw waveform register.
    always_ff @(posedge clk) begin
        if (!rst_n)   raw <= 1'b0;
        else if (run) raw <= apply_act(raw, code);
    end

    // R8
    hold_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(raw));

endmodule

// File: rtl/epwm_edge_delay.sv
// Delays the rising edge of its input by dly+1 clocks; falling edge
// passes after one clock. Highs shorter than dly+1 clocks are dropped.
module epwm_edge_delay #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [DW-1:0] dly,
    output logic          dout
);

    logic [DW-1:0] wait_q;

    // Count high time and release the output after the delay.
    always_ff @(posedge clk) begin
        if (!rst_n || !din) begin
            wait_q <= '0;
            dout   <= 1'b0;
        end else if (wait_q >= dly) begin
            dout   <= 1'b1;
        end else begin
            wait_q <= wait_q + 1'b1;
        end
    end

    // R9
    rise_after_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout) |-> $past(din));

    // R10
    low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !din |=> !dout);

endmodule

// File: rtl/epwm_pair.sv
// Top: run control, time base, action qualifier, dead-band pair and
// fault override. The N side is the delayed complement of the raw wave;
// the fault override sits after the dead band and is combinational.
module epwm_pair
    import epwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DBW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [CW-1:0]    period,
    input  logic [CW-1:0]    phase,
    input  logic             phase_ld,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             ext_start,
    input  logic             ext_stop,
    input  logic [CW-1:0]    cmp_a,
    input  logic [CW-1:0]    cmp_b,
    input  logic [ACT_W-1:0] act_cfg,
    input  logic [DBW-1:0]   db_rise,
    input  logic [DBW-1:0]   db_fall,
    input  logic             trip,
    input  logic [1:0]       trip_p_cfg,
    input  logic [1:0]       trip_n_cfg,
    output logic [CW-1:0]    ctr,
    output logic             pwm_p,
    output logic             pwm_n,
    output logic             oe_p,
    output logic             oe_n
);

    localparam int NSIDE = 2;

    logic           run_q;
    logic           raw;
    tb_evt_t        evt;
    logic [NSIDE-1:0] db_in;
    logic [NSIDE-1:0] db_out;
    logic [DBW-1:0] db_dly [NSIDE];

    // Run flag: stop strobes override start strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)                    run_q <= 1'b0;
        else if (sw_stop || ext_stop)  run_q <= 1'b0;
        else if (sw_start || ext_start) run_q <= 1'b1;
    end

    epwm_timebase #(.CW(CW)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .mode     (mode),
        .period   (period),
        .phase    (phase),
        .phase_ld (phase_ld),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .cnt      (ctr),
        .evt      (evt)
    );

    epwm_action u_aq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .evt     (evt),
        .act_cfg (act_cfg),
        .raw     (raw)
    );

    assign db_in[0]  = raw;
    assign db_in[1]  = ~raw;
    assign db_dly[0] = db_rise;
    assign db_dly[1] = db_fall;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        epwm_edge_delay #(.DW(DBW)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (db_in[g]),
            .dly   (db_dly[g]),
            .dout  (db_out[g])
        );
    end

    // Fault override after the dead band.
    always_comb begin
        if (trip) begin
            {oe_p, pwm_p} = trip_drive(trip_p_cfg);
            {oe_n, pwm_n} = trip_drive(trip_n_cfg);
        end else begin
            {oe_p, pwm_p} = {1'b1, db_out[0]};
            {oe_n, pwm_n} = {1'b1, db_out[1]};
        end
    end

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(db_out[0] && db_out[1]));

    // R8
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stop || ext_stop) |=> !run_q);

endmodule

// File: tb/epwm_pair_tb.sv
module epwm_pair_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] period = 16'd7;
    logic [15:0] phase = 16'd0;
    logic        phase_ld = 1'b0;
    logic        sw_start = 1'b0, sw_stop = 1'b0, ext_start = 1'b0, ext_stop = 1'b0;
    logic [15:0] cmp_a = 16'd3, cmp_b = 16'd5;
    logic [11:0] act_cfg = 12'd0;
    logic [15:0] db_rise = 16'd0, db_fall = 16'd0;
    logic        trip = 1'b0;
    logic [1:0]  trip_p_cfg = 2'b00, trip_n_cfg = 2'b00;
    logic [15:0] ctr;
    logic        pwm_p, pwm_n, oe_p, oe_n;

    epwm_pair u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .period(period), .phase(phase),
        .phase_ld(phase_ld), .sw_start(sw_start), .sw_stop(sw_stop),
        .ext_start(ext_start), .ext_stop(ext_stop), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .act_cfg(act_cfg), .db_rise(db_rise), .db_fall(db_fall), .trip(trip),
        .trip_p_cfg(trip_p_cfg), .trip_n_cfg(trip_n_cfg), .ctr(ctr),
        .pwm_p(pwm_p), .pwm_n(pwm_n), .oe_p(oe_p), .oe_n(oe_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // Behavioural reference state.
    int m_cnt, m_pc, m_nc;
    bit m_up, m_run, m_raw, m_pd, m_nd;

    always @(posedge clk) begin
        bit rising;
        logic [1:0] code;
        armed <= 1'b1;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_run = 0; m_raw = 0;
            m_pd = 0; m_pc = 0; m_nd = 0; m_nc = 0;
        end else begin
            // dead band reacts to the previous raw level
            if (m_raw) begin
                if (m_pc >= int'(db_rise)) m_pd = 1; else m_pc++;
                m_nd = 0; m_nc = 0;
            end else begin
                if (m_nc >= int'(db_fall)) m_nd = 1; else m_nc++;
                m_pd = 0; m_pc = 0;
            end
            // action from the previous count
            if (m_run) begin
                rising = (mode == 2'b01) ? 1'b0 : (mode == 2'b10) ? m_up : 1'b1;
                if (m_cnt == 0)                   code = act_cfg[1:0];
                else if (m_cnt == int'(period))   code = act_cfg[3:2];
                else if (m_cnt == int'(cmp_b))    code = rising ? act_cfg[7:6] : act_cfg[11:10];
                else if (m_cnt == int'(cmp_a))    code = rising ? act_cfg[5:4] : act_cfg[9:8];
                else                              code = 2'b00;
                if (code == 2'b01) m_raw = 0;
                else if (code == 2'b10) m_raw = 1;
                else if (code == 2'b11) m_raw = !m_raw;
            end
            // counter
            if (phase_ld) begin
                m_cnt = int'(phase); m_up = 1;
            end else if (m_run) begin
                if (mode == 2'b01) begin
                    m_cnt = (m_cnt == 0) ? int'(period) : m_cnt - 1;
                end else if (mode == 2'b10) begin
                    if (m_up) begin
                        if (m_cnt >= int'(period)) begin m_cnt--; m_up = 0; end
                        else m_cnt++;
                    end else if (m_cnt == 0) begin
                        m_cnt = 1; m_up = 1;
                    end else m_cnt--;
                end else begin
                    m_cnt = (m_cnt >= int'(period)) ? 0 : m_cnt + 1;
                end
            end
            if (sw_stop || ext_stop) m_run = 0;
            else if (sw_start || ext_start) m_run = 1;
        end
    end

    // Compare every output against the model once per clock.
    always @(negedge clk) begin
        bit ep, en, eop, eon;
        cycles++;
        if (armed && !done) begin
            {eop, ep} = trip ? (trip_p_cfg[1] ? 2'b00 : {1'b1, trip_p_cfg[0]}) : {1'b1, m_pd};
            {eon, en} = trip ? (trip_n_cfg[1] ? 2'b00 : {1'b1, trip_n_cfg[0]}) : {1'b1, m_nd};
            vectors++;
            if (int'(ctr) != m_cnt || pwm_p !== ep || pwm_n !== en || oe_p !== eop || oe_n !== eon) begin
                fails++;
                $display("FAIL %s t=%0t actual ctr=%0d p=%b n=%b oep=%b oen=%b expected ctr=%0d p=%b n=%b oep=%b oen=%b",
                         cur_tag, $time, ctr, pwm_p, pwm_n, oe_p, oe_n, m_cnt, ep, en, eop, eon);
            end
        end
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_tag);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    function automatic logic [11:0] acts(input logic [1:0] z, p, au, bu, ad, bd);
        return {bd, ad, bu, au, p, z};
    endfunction

    initial begin
        // R1: reset state
        cur_tag = "R1";
        step(4);
        rst_n = 1'b1;
        step(3);

        // R2 + R5: up count, set at zero, clear at A, toggle at B
        cur_tag = "R2";
        act_cfg = acts(2'b10, 2'b00, 2'b01, 2'b11, 2'b00, 2'b00);
        sw_start = 1'b1; step(1); sw_start = 1'b0;
        step(30);

        // R5: toggle code on the zero event only
        cur_tag = "R5";
        act_cfg = acts(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        step(24);

        // R3: down count with falling-direction compare codes
        cur_tag = "R3";
        mode = 2'b01;
        act_cfg = acts(2'b00, 2'b10, 2'b10, 2'b10, 2'b01, 2'b11);
        step(30);

        // R4: up-down with direction-qualified A
        cur_tag = "R4";
        mode = 2'b10;
        act_cfg = acts(2'b00, 2'b00, 2'b10, 2'b00, 2'b01, 2'b00);
        step(40);
        mode = 2'b11;
        step(12);

        // R6: A at zero and B at period collide with higher events
        cur_tag = "R6";
        mode = 2'b00; cmp_a = 16'd0; cmp_b = 16'd7;
        act_cfg = acts(2'b10, 2'b01, 2'b01, 2'b10, 2'b00, 2'b00);
        step(24);
        act_cfg = acts(2'b00, 2'b00, 2'b10, 2'b01, 2'b00, 2'b00);
        step(20);

        // R12: equal compares, B wins
        cur_tag = "R12";
        cmp_a = 16'd4; cmp_b = 16'd4;
        act_cfg = acts(2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b00);
        step(20);

        // R7: phase preset mid-run, inside and beyond the period
        cur_tag = "R7";
        cmp_a = 16'd2; cmp_b = 16'd6;
        act_cfg = acts(2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00);
        phase = 16'd5; phase_ld = 1'b1; step(1); phase_ld = 1'b0;
        step(6);
        phase = 16'd12; phase_ld = 1'b1; step(1); phase_ld = 1'b0;
        step(6);
        mode = 2'b10;
        step(5);
        phase = 16'd3; phase_ld = 1'b1; step(1); phase_ld = 1'b0;
        step(12);
        mode = 2'b00;

        // R8: external stop/start, simultaneous start and stop
        cur_tag = "R8";
        ext_stop = 1'b1; step(1); ext_stop = 1'b0;
        step(8);
        ext_start = 1'b1; step(1); ext_start = 1'b0;
        step(6);
        sw_start = 1'b1; sw_stop = 1'b1; step(1); sw_start = 1'b0; sw_stop = 1'b0;
        step(6);
        sw_start = 1'b1; step(1); sw_start = 1'b0;
        step(6);

        // R9 + R10: dead-band delays on both sides
        cur_tag = "R9";
        period = 16'd15; cmp_a = 16'd9;
        act_cfg = acts(2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00);
        db_rise = 16'd3; db_fall = 16'd5;
        step(50);
        cur_tag = "R10";
        db_rise = 16'd12; db_fall = 16'd1;
        step(50);
        db_rise = 16'd0; db_fall = 16'd8;
        step(40);

        // R11: fault states on each output
        cur_tag = "R11";
        trip = 1'b1; trip_p_cfg = 2'b00; trip_n_cfg = 2'b01; step(5);
        trip_p_cfg = 2'b01; trip_n_cfg = 2'b10; step(5);
        trip_p_cfg = 2'b11; trip_n_cfg = 2'b00; step(5);
        trip = 1'b0; step(20);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule